// File: doc/BRIEF.md
# Conditional carry adder

This block adds two unsigned operand vectors and a carry-in and returns the sum vector and a true-high carry-out. It is purely combinational. For every bit it forms two candidate carries, one for a group carry-in of 0 and one for a group carry-in of 1. A tree of two-input selectors then resolves them, with the group size doubling at each level. Only carries travel through the tree. Each sum bit is formed at the very end by a three-input XOR of the two operand bits and the resolved carry into that bit.

The per-bit candidates are produced in complemented form: a NAND for the carry-in-0 case and a NOR for the carry-in-1 case, which are the two reductions of the minority function. Every selector in the tree returns the complement of the input it picks, so the polarity of the carries alternates from level to level. The polarity is tracked at elaboration time. An inverted select is absorbed by swapping the selector's data inputs, and an inverted carry is absorbed by the final XOR, which is built as an XNOR when needed. A parameter can merge the last tree level and the carry-in selection into one stage. In that stage two enabled selectors drive a shared output, and the carry-in enables exactly one of them.

Top module: `cond_carry_adder`

## Requirements
- R1: For every input, `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, for WIDTH of 4, 8 and 16.
- R2: `cout_o` is high exactly when `a_i + b_i + cin_i` is at least 2^WIDTH.
- R3: When every bit position propagates (`a_i ^ b_i` all ones), `cout_o` equals `cin_i`. With `cin_i` = 1, `sum_o` is all zeros.
- R4: With both operands zero, `sum_o` equals `cin_i` zero-extended and `cout_o` is 0.
- R5: The merged final-stage variant (`MERGE_LAST` = 1) gives outputs identical to the two-stage variant (`MERGE_LAST` = 0) for every input. In the merged stage, exactly one of its two selector branches is enabled at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit, true-high |

## Verification
The hardest condition to reach is a carry that is generated at bit 0 and has to be resolved through every selector level up to the top sum bit, together with the merged stage choosing the opposite branch from the one a local carry would suggest. Random vectors rarely produce a full-length propagate chain at 16 bits. The stimulus therefore covers widths 4 and 8 exhaustively, for both variants. At 16 bits it uses directed all-propagate patterns with both carry-in values, along with seeded random vectors.

// File: rtl/cca_pkg.sv
package cca_pkg;
   localparam int unsigned CCA_MIN_WIDTH = 4;
   localparam int unsigned CCA_MAX_WIDTH = 16;

   // Stored polarity of the conditional carries after a given tree level:
   // 1 means the stored value is the complement of the carry.
   function automatic bit level_inverted(input int unsigned lvl);
      return (lvl % 2) == 0;
   endfunction
endpackage

// File: rtl/cca_nmux.sv
module cca_nmux #(
   parameter bit SWAP = 1'b0
) (
   input  logic d0,
   input  logic d1,
   input  logic s,
   output logic y
);
   generate
      if (SWAP) begin : g_swapped
         assign y = ~(s ? d0 : d1);
      end else begin : g_straight
         assign y = ~(s ? d1 : d0);
      end
   endgenerate
endmodule

// File: rtl/cca_nmux_merged.sv
module cca_nmux_merged #(
   parameter bit SWAP = 1'b0
) (
   input  logic d0,
   input  logic d1,
   input  logic s_lo,
   input  logic s_hi,
   input  logic en,
   output logic y
);
   logic lo_en, hi_en;
   logic lo_pick, hi_pick;

   assign lo_en = ~en;
   assign hi_en = en;

   generate
      if (SWAP) begin : g_swapped
         assign lo_pick = s_lo ? d0 : d1;
         assign hi_pick = s_hi ? d0 : d1;
      end else begin : g_straight
         assign lo_pick = s_lo ? d1 : d0;
         assign hi_pick = s_hi ? d1 : d0;
      end
   endgenerate

   // two enabled branches sharing one output, modelled as and-or
   assign y = (lo_en & ~lo_pick) | (hi_en & ~hi_pick);

   always_comb begin
      p_one_driver_r5: assert ($onehot({lo_en, hi_en}))
         else $error("merged stage drives with %b", {lo_en, hi_en});
   end
endmodule

// File: rtl/cca_xor3.sv
module cca_xor3 #(
   parameter bit C_INV = 1'b0
) (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic s
);
   generate
      if (C_INV) begin : g_xnor
         assign s = ~(a ^ b ^ c);
      end else begin : g_xor
         assign s = a ^ b ^ c;
      end
   endgenerate
endmodule

// File: rtl/cond_carry_adder.sv
module cond_carry_adder
   import cca_pkg::*;
#(
   parameter int unsigned WIDTH      = 16,
   parameter bit          MERGE_LAST = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   localparam int unsigned LEVELS = $clog2(WIDTH);
   localparam int unsigned TREE   = MERGE_LAST ? LEVELS - 1 : LEVELS;
   localparam int unsigned HALF   = WIDTH / 2;
   localparam bit          C_POL  = MERGE_LAST ? !level_inverted(LEVELS - 1)
                                               : !level_inverted(LEVELS);

   generate
      if (!(WIDTH == 4 || WIDTH == 8 || WIDTH == 16)) begin : g_bad_width
         $error("cond_carry_adder: WIDTH %0d not in {4,8,16}", WIDTH);
      end
      if (WIDTH < CCA_MIN_WIDTH || WIDTH > CCA_MAX_WIDTH) begin : g_bad_range
         $error("cond_carry_adder: WIDTH out of range");
      end
   endgenerate

   // conditional carries per level: kz = group carry-in 0, ko = carry-in 1
   logic [TREE:0][WIDTH-1:0] kz;
   logic [TREE:0][WIDTH-1:0] ko;
   logic [WIDTH-1:0]         cres;    // resolved carry out of each bit, polarity C_POL
   logic [WIDTH-1:0]         cin_bit; // carry into each bit, true polarity handled in xor

   // level 0: minority reductions, complemented candidates
   assign kz[0] = ~(a_i & b_i);
   assign ko[0] = ~(a_i | b_i);

   genvar lv, i;
   generate
      for (lv = 1; lv <= TREE; lv++) begin : g_lvl
         localparam int unsigned GRP = 1 << lv;
         localparam int unsigned HG  = GRP / 2;
         localparam bit          SW  = level_inverted(lv - 1);
         for (i = 0; i < WIDTH; i++) begin : g_bit
            localparam int unsigned SRC = (i / GRP) * GRP + HG - 1;
            if ((i % GRP) >= HG) begin : g_sel
               cca_nmux #(.SWAP(SW)) u_mz (
                  .d0(kz[lv-1][i]), .d1(ko[lv-1][i]), .s(kz[lv-1][SRC]), .y(kz[lv][i]));
               cca_nmux #(.SWAP(SW)) u_mo (
                  .d0(kz[lv-1][i]), .d1(ko[lv-1][i]), .s(ko[lv-1][SRC]), .y(ko[lv][i]));
            end else begin : g_pass
               assign kz[lv][i] = ~kz[lv-1][i];
               assign ko[lv][i] = ~ko[lv-1][i];
            end
         end
      end

      for (i = 0; i < WIDTH; i++) begin : g_fin
         if (MERGE_LAST && i >= HALF) begin : g_merged
            cca_nmux_merged #(.SWAP(level_inverted(LEVELS - 1))) u_mm (
               .d0(kz[TREE][i]), .d1(ko[TREE][i]),
               .s_lo(kz[TREE][HALF-1]), .s_hi(ko[TREE][HALF-1]),
               .en(cin_i), .y(cres[i]));
         end else begin : g_cin
            cca_nmux #(.SWAP(1'b0)) u_mc (
               .d0(kz[TREE][i]), .d1(ko[TREE][i]), .s(cin_i), .y(cres[i]));
         end
      end

      assign cin_bit[0] = cin_i;
      cca_xor3 #(.C_INV(1'b0)) u_s0 (
         .a(a_i[0]), .b(b_i[0]), .c(cin_bit[0]), .s(sum_o[0]));
      for (i = 1; i < WIDTH; i++) begin : g_sum
         assign cin_bit[i] = cres[i-1];
         cca_xor3 #(.C_INV(C_POL)) u_sx (
            .a(a_i[i]), .b(b_i[i]), .c(cin_bit[i]), .s(sum_o[i]));
      end

      if (C_POL) begin : g_cout_inv
         assign cout_o = ~cres[WIDTH-1];
      end else begin : g_cout_true
         assign cout_o = cres[WIDTH-1];
      end
   endgenerate

   logic [WIDTH:0] chk_total;
   always_comb begin
      chk_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
      p_sum_r1: assert (sum_o == chk_total[WIDTH-1:0])
         else $error("sum %h expected %h", sum_o, chk_total[WIDTH-1:0]);
      p_cout_r2: assert (cout_o == chk_total[WIDTH])
         else $error("cout %b expected %b", cout_o, chk_total[WIDTH]);
      if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
         p_propagate_r3: assert (cout_o == cin_i)
            else $error("full propagate cout %b cin %b", cout_o, cin_i);
      end
      if (a_i == '0 && b_i == '0) begin
         p_zero_r4: assert (sum_o == {{(WIDTH-1){1'b0}}, cin_i} && !cout_o)
            else $error("zero operands gave %b %h", cout_o, sum_o);
      end
   end
endmodule

// File: tb/tb_cond_carry_adder.sv
`timescale 1ns/1ps
module tb_cond_carry_adder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   logic [15:0] a16, b16; logic c16;
   logic [7:0]  a8, b8;   logic c8;
   logic [3:0]  a4, b4;   logic c4;
   logic [15:0] s16m, s16p; logic o16m, o16p;
   logic [7:0]  s8m, s8p;   logic o8m, o8p;
   logic [3:0]  s4m, s4p;   logic o4m, o4p;

   cond_carry_adder #(.WIDTH(16), .MERGE_LAST(1'b1)) dut (
      .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16m), .cout_o(o16m));
   cond_carry_adder #(.WIDTH(16), .MERGE_LAST(1'b0)) dut_p16 (
      .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16p), .cout_o(o16p));
   cond_carry_adder #(.WIDTH(8), .MERGE_LAST(1'b1)) dut_m8 (
      .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8m), .cout_o(o8m));
   cond_carry_adder #(.WIDTH(8), .MERGE_LAST(1'b0)) dut_p8 (
      .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8p), .cout_o(o8p));
   cond_carry_adder #(.WIDTH(4), .MERGE_LAST(1'b1)) dut_m4 (
      .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4m), .cout_o(o4m));
   cond_carry_adder #(.WIDTH(4), .MERGE_LAST(1'b0)) dut_p4 (
      .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4p), .cout_o(o4p));

   function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                           input logic c, input int w);
      logic [16:0] t;
      logic [16:0] mask;
      t = {1'b0, a} + {1'b0, b} + {16'd0, c};
      mask = (17'd1 << (w + 1)) - 17'd1;
      return t & mask;
   endfunction

   task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c, input string req);
      logic [16:0] e;
      a16 = a; b16 = b; c16 = c;
      #1;
      e = ref_add(a, b, c, 16);
      chk(req, {o16m, s16m}, e);
      chk("R5 merged vs plain 16", {o16m, s16m}, {o16p, s16p});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      a16 = '0; b16 = '0; c16 = 1'b0;
      a8 = '0; b8 = '0; c8 = 1'b0;
      a4 = '0; b4 = '0; c4 = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state: zero operands, zero carry (R4)
      chk("R4 reset zero 16", {o16m, s16m}, 17'd0);
      chk("R4 reset zero 8", {8'd0, o8m, s8m}, 17'd0);
      chk("R4 reset zero 4", {12'd0, o4m, s4m}, 17'd0);

      // R4: zero operands with carry-in
      run16(16'h0000, 16'h0000, 1'b1, "R4 zero with cin");

      // R3: full propagate chains from bit 0 to the top
      run16(16'hFFFF, 16'h0000, 1'b1, "R3 propagate cin1");
      run16(16'hFFFF, 16'h0000, 1'b0, "R3 propagate cin0");
      run16(16'hAAAA, 16'h5555, 1'b1, "R3 alternating cin1");
      run16(16'h5555, 16'hAAAA, 1'b0, "R3 alternating cin0");
      // R2: generate at bit 0 rippling to the carry-out
      run16(16'hFFFF, 16'h0001, 1'b0, "R2 bit0 generate");
      run16(16'hFFFF, 16'hFFFF, 1'b1, "R2 all ones");
      run16(16'h8000, 16'h8000, 1'b0, "R2 top generate");
      run16(16'h7FFF, 16'h0001, 1'b0, "R1 ripple to msb");

      // R1/R2 at width 16: seeded random vectors
      for (int n = 0; n < 3000; n++) begin
         run16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random 16");
      end

      // R1/R2/R5 exhaustive at width 4
      for (int v = 0; v < 512; v++) begin
         logic [16:0] e4;
         a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
         #1;
         e4 = ref_add({12'd0, a4}, {12'd0, b4}, c4, 4);
         chk("R1 R2 exhaustive 4", {12'd0, o4m, s4m}, e4);
         chk("R5 merged vs plain 4", {12'd0, o4m, s4m}, {12'd0, o4p, s4p});
      end

      // R1/R2/R5 exhaustive at width 8
      for (int v = 0; v < 131072; v++) begin
         logic [16:0] e8;
         a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
         #1;
         e8 = ref_add({8'd0, a8}, {8'd0, b8}, c8, 8);
         if ({8'd0, o8m, s8m} !== e8 || {o8m, s8m} !== {o8p, s8p}) begin
            chk("R1 R2 exhaustive 8", {8'd0, o8m, s8m}, e8);
            chk("R5 merged vs plain 8", {8'd0, o8m, s8m}, {8'd0, o8p, s8p});
         end else begin
            checks += 2;
         end
      end

      finish_run();
   end
endmodule